// File: doc/BRIEF.md
# Processor Flag Register with Single-Bit Set and Clear

This block holds the eight condition and control flags of a small processor core in one register. Three sources can write it: the arithmetic unit, which presents a full flag vector together with a per-bit write mask; a decoded instruction that forces one selected flag to one; and a decoded instruction that forces one selected flag to zero. Both bit instructions share a single opcode pattern. Bit 7 of the instruction word chooses between set and clear, and bits 6:4 give the flag index.

The register value is visible on an output port. The global interrupt-enable flag is also driven on a separate output for the interrupt logic. Every write takes effect on the clock edge that samples it, so each bit instruction completes in one cycle.

Top module: `flag_reg_top`

## Requirements
- R1: After reset the register reads 0x00, and the interrupt-enable output is 0.
- R2: Flag positions are: interrupt enable = bit 7, transfer bit = 6, half carry = 5, sign = 4, overflow = 3, negative = 2, zero = 1, carry = 0.
- R3: With the valid strobe high, a word matching 1001 0100 0sss 1000 (bits 15:8 = 0x94, bit 7 = 0, bits 3:0 = 0x8) sets flag s (bits 6:4) to 1 on the next edge. All other flags keep their values.
- R4: With the valid strobe high, a word matching 1001 0100 1sss 1000 (bit 7 = 1) clears flag s to 0 on the next edge. All other flags keep their values.
- R5: Each bit instruction finishes in one cycle. Back-to-back instructions on consecutive cycles each take effect in turn.
- R6: When no bit instruction is accepted, an ALU update writes each flag whose mask bit is 1 with the matching ALU value. Flags whose mask bit is 0 keep their values.
- R7: When a bit instruction and an ALU update fall in the same cycle, only the bit instruction takes effect, and the ALU update is discarded.
- R8: A word that matches neither pattern leaves the register unchanged. A matching word with the valid strobe low also leaves it unchanged.
- R9: The interrupt-enable output always equals register bit 7. Setting index 7 enables interrupts, and clearing index 7 disables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrWord | input | 16 | Instruction word from the decoder |
| instrValid | input | 1 | Instruction word is valid this cycle |
| aluFlags | input | 8 | Flag values computed by the ALU |
| aluMask | input | 8 | Per-flag write enable for the ALU update |
| flagsOut | output | 8 | Current register value |
| intEnable | output | 1 | Global interrupt enable (bit 7) |

## Verification
The hardest case to reach from the ports is a bit instruction and a non-zero ALU mask arriving together. In that cycle the ALU values must be dropped even for flags other than the addressed one. Random cycles assert the strobe and a non-zero mask together often enough to hit this case. Directed cycles also pair a set with a mask that would clear every other flag. A further set of near-miss words differs from the pattern by one bit, to show that these are ignored.

// File: rtl/flag_reg_pkg.sv
package flag_reg_pkg;
  localparam int FlagW = 8;
  localparam int IdxW = $clog2(FlagW);
  localparam int WordW = 16;
  localparam int IntBit = 7;

  typedef struct packed {
    logic bitWrite;
    logic bitValue;
    logic [IdxW-1:0] bitIdx;
    logic aluWrite;
  } flagCtrl_t;
endpackage

// File: rtl/flag_decode.sv
module flag_decode
  import flag_reg_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [WordW-1:0] instrWord,
  input  logic instrValid,
  input  logic [FlagW-1:0] aluMask,
  output flagCtrl_t ctrl
);
  logic isBitOp;

  always_comb begin
    isBitOp = instrValid && (instrWord[15:8] == 8'h94) && (instrWord[3:0] == 4'h8);
    ctrl.bitWrite = isBitOp;
    ctrl.bitValue = ~instrWord[7];
    ctrl.bitIdx = instrWord[6:4];
    ctrl.aluWrite = !isBitOp && (aluMask != '0);
  end

  // R7: a bit instruction and an ALU write are never issued in the same cycle
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.bitWrite && ctrl.aluWrite));

  // R8: a word with the strobe low never produces a bit write
  assert_no_write_invalid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !ctrl.bitWrite);
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_reg_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  flagCtrl_t ctrl,
  input  logic [FlagW-1:0] aluFlags,
  input  logic [FlagW-1:0] aluMask,
  output logic [FlagW-1:0] flags
);
  logic [FlagW-1:0] nextFlags;

  for (genvar i = 0; i < FlagW; i++) begin : gBit
    always_comb begin
      if (ctrl.bitWrite && ctrl.bitIdx == IdxW'(i)) nextFlags[i] = ctrl.bitValue;
      else if (ctrl.aluWrite && aluMask[i]) nextFlags[i] = aluFlags[i];
      else nextFlags[i] = flags[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else flags <= nextFlags;
  end

  // R3/R4: the addressed flag takes the requested value one edge later
  assert_bit_applied_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.bitWrite |=> flags[$past(ctrl.bitIdx)] == $past(ctrl.bitValue));

  // R4: a bit instruction changes at most one flag
  assert_single_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.bitWrite |=> $countones(flags ^ $past(flags)) <= 1);

  // R8: with no write source active the register holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.bitWrite && !ctrl.aluWrite) |=> $stable(flags));
endmodule

// File: rtl/flag_reg_top.sv
module flag_reg_top
  import flag_reg_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic [15:0] instrWord,
  input  logic instrValid,
  input  logic [7:0] aluFlags,
  input  logic [7:0] aluMask,
  output logic [7:0] flagsOut,
  output logic intEnable
);
  flagCtrl_t ctrl;
  logic [FlagW-1:0] flags;

  flag_decode uDec (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .instrValid(instrValid),
    .aluMask(aluMask), .ctrl(ctrl)
  );

  flag_store uStore (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .aluFlags(aluFlags),
    .aluMask(aluMask), .flags(flags)
  );

  assign flagsOut = flags;
  assign intEnable = flags[IntBit];

  // R9: the interrupt enable follows the top flag
  assert_int_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    intEnable == flagsOut[7]);

  // R6: masked-off flags keep their value on an ALU-only cycle
  assert_alu_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(instrValid && instrWord[15:8] == 8'h94 && instrWord[3:0] == 4'h8))
    |=> ((flagsOut ^ $past(flagsOut)) & ~$past(aluMask)) == '0);
endmodule

// File: tb/sim_flag_reg_top.sv
module sim_flag_reg_top;
  logic clk = 0;
  logic rstN = 0;
  logic [15:0] instrWord = '0;
  logic instrValid = 0;
  logic [7:0] aluFlags = '0;
  logic [7:0] aluMask = '0;
  logic [7:0] flagsOut;
  logic intEnable;
  int checks = 0;
  int failures = 0;
  logic [7:0] model = '0;
  bit done = 0;

  always #2 clk = ~clk;

  flag_reg_top u0 (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .instrValid(instrValid),
    .aluFlags(aluFlags), .aluMask(aluMask), .flagsOut(flagsOut), .intEnable(intEnable)
  );

  function automatic logic [7:0] nextModel(logic [7:0] cur, logic [15:0] w, logic v,
                                           logic [7:0] af, logic [7:0] am);
    logic [7:0] r = cur;
    if (v && w[15:8] == 8'h94 && w[3:0] == 4'h8) r[w[6:4]] = ~w[7];
    else r = (cur & ~am) | (af & am);
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [15:0] w, logic v, logic [7:0] af, logic [7:0] am);
    instrWord = w; instrValid = v; aluFlags = af; aluMask = am;
    model = nextModel(model, w, v, af, am);
    @(posedge clk); #1;
    instrValid = 0; aluMask = '0;
    check(req, flagsOut, model);
    check("R9", {7'd0, intEnable}, {7'd0, model[7]});
  endtask

  function automatic logic [15:0] bitOp(bit clr, int idx);
    return {8'h94, clr, 3'(idx), 4'h8};
  endfunction

  initial begin
    process::self().srandom(32'd1234);
    #7; check("R1", flagsOut, 8'h00); check("R1", {7'd0, intEnable}, 8'h00);
    rstN = 1; @(negedge clk);
    for (int i = 0; i < 8; i++) step("R3", bitOp(0, i), 1, 8'h00, 8'h00);
    for (int i = 7; i >= 0; i--) step("R4", bitOp(1, i), 1, 8'hFF, 8'h00);
    step("R9", bitOp(0, 7), 1, 0, 0);
    step("R9", bitOp(1, 7), 1, 0, 0);
    step("R2", bitOp(0, 0), 1, 0, 0);
    check("R2", flagsOut, 8'h01);
    step("R6", 16'h0000, 0, 8'hA5, 8'hF0);
    step("R6", 16'h0000, 0, 8'h5A, 8'h0F);
    step("R7", bitOp(0, 3), 1, 8'h00, 8'hFF);
    step("R7", bitOp(1, 5), 1, 8'hFF, 8'hFF);
    step("R8", bitOp(0, 2), 0, 0, 0);
    for (int b = 0; b < 16; b++)
      if (!(b >= 4 && b <= 7)) step("R8", bitOp(0, 6) ^ (16'h1 << b), 1, 0, 0);
    step("R5", bitOp(0, 1), 1, 0, 0);
    step("R5", bitOp(0, 4), 1, 0, 0);
    step("R5", bitOp(1, 1), 1, 0, 0);
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] w;
      int sel = $urandom_range(0, 3);
      w = (sel < 2) ? bitOp(1'($urandom), $urandom_range(0, 7)) : 16'($urandom);
      step("R7", w, 1'($urandom), 8'($urandom), 8'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; failures++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule